// File: doc/BRIEF.md
# Camera Pixel Output Formatter

This block sits at the end of a camera image pipeline and drives an 8-bit parallel camera port. The upstream stage delivers one pixel as separate luma (Y) and chroma (Cb, Cr) samples, together with a frame-valid and a line-valid marker. The block turns each pixel into two byte beats. It can send them as YCbCr 4:2:2, or it can convert the pixel to RGB and pack it as 5/6/5, 5/5/5 or 4/4/4 bits. Alongside the data it produces a vertical sync, a horizontal sync and a pixel-clock enable. The polarity of both syncs and the gating of the pixel clock are programmable.

The block runs on the byte clock, which is twice the pixel rate. While line-valid is high, the upstream stage holds every pixel for two consecutive cycles, and each line spans an even number of cycles. The format and byte-order controls and the pixel-clock edge choice are sampled once, on the cycle in which frame-valid rises. The rest of the frame therefore uses one consistent layout. Sync polarity, sync qualification and clock gating act on the next clock edge. The nominal image is 640 x 480 pixels, but the block has no fixed line length.

Top module: `cam_pix_formatter`

## Requirements
- R1: While reset is asserted, the outputs are: data 0x00, pixel-clock enable 0, pixel-clock edge select 0, HSYNC 1 and VSYNC 1.
- R2: Call the second cycle of each pixel's two-cycle hold cycle c. The pixel's first byte appears on the data bus after the edge that ends cycle c. Its second byte appears one cycle later. In every cycle that carries no byte, the bus reads 0x00.
- R3: Format code 0 selects YCbCr 4:2:2. Pixels in a line are counted from 0, and each pixel carries one chroma sample: Cb for even pixels and Cr for odd pixels. The chroma-swap control exchanges Cb and Cr. With the luma/chroma-swap control at 1, the chroma byte goes first and the luma byte second; with it at 0, luma goes first.
- R4: Format codes 1 to 3 convert YCbCr to RGB with 8 fraction bits and rounding. With u = Cb-128 and v = Cr-128, the conversion is R = Y + ((359v+128)>>>8), G = Y - ((88u+183v+128)>>>8) and B = Y + ((454u+128)>>>8). Each result is clamped to the range 0..255.
- R5: Format code 1 sends the 16-bit word {R[7:3], G[7:2], B[7:3]}, upper byte first.
- R6: Format code 2 sends the 16-bit word {0, R[7:3], G[7:3], B[7:3]}, upper byte first.
- R7: Format code 3 sends the 16-bit word {0000, R[7:4], G[7:4], B[7:4]}, upper byte first.
- R8: The format, both swap controls and the pixel-clock edge select are captured on the edge at which frame-valid is first seen high. Changing them at any other time has no effect until the next frame.
- R9: VSYNC carries frame-valid delayed by one cycle, XOR the VSYNC invert control.
- R10: HSYNC is active (before the invert control is XORed in) in exactly the cycles that carry a byte. When the HSYNC-inside-VSYNC option is set, HSYNC is also forced inactive wherever VSYNC is inactive.
- R11: With gating off, the pixel-clock enable is 1 in every cycle after reset. With gating on, it is 1 only in cycles where HSYNC and VSYNC are both active.
- R12: The pixel-clock edge select output reflects the invert control captured at frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid | input | 1 | Frame marker from the pipeline |
| line_valid | input | 1 | Line marker; each pixel is held for two cycles |
| pix_y | input | 8 | Luma sample |
| pix_cb | input | 8 | Blue-difference sample |
| pix_cr | input | 8 | Red-difference sample |
| cfg_format | input | 2 | 0 YCbCr 4:2:2, 1 RGB 5/6/5, 2 RGB 5/5/5, 3 RGB 4/4/4 |
| cfg_uv_swap | input | 1 | Exchange Cb and Cr order |
| cfg_yc_swap | input | 1 | 1 sends chroma before luma |
| cfg_vsync_inv | input | 1 | Invert VSYNC |
| cfg_hsync_inv | input | 1 | Invert HSYNC |
| cfg_pclk_inv | input | 1 | Select the falling pixel-clock edge |
| cfg_pclk_gate | input | 1 | Gate the pixel clock to active sync periods |
| cfg_hsync_in_vsync | input | 1 | Suppress HSYNC outside the VSYNC window |
| cam_data | output | 8 | Parallel byte bus |
| cam_pclk_en | output | 1 | Pixel clock run enable for the pad clock cell |
| cam_pclk_neg | output | 1 | Pixel clock edge select for the pad clock cell |
| cam_hsync | output | 1 | Horizontal sync |
| cam_vsync | output | 1 | Vertical sync |

## Verification
The hardest case to reach from the ports is a line whose line-valid lies wholly outside frame-valid. Only such a line shows that HSYNC and the gated pixel clock are suppressed while the data beats still flow with the previous frame's layout. The bench reaches it by driving blanking lines between frames, once with HSYNC qualification on and once with it off. A second hard case is a configuration change in the middle of a frame: the stimulus flips the format, both swaps and the clock edge after the first line and checks that the rest of the frame keeps the captured layout. Saturation of the colour conversion is forced with extreme Y/Cb/Cr triples at the start of every frame.

// File: rtl/camfmt_pkg.sv
package camfmt_pkg;

    localparam int PIX_W   = 8;
    localparam int WORD_W  = 2 * PIX_W;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef enum logic [1:0] {
        FMT_YUV422 = 2'd0,
        FMT_RGB565 = 2'd1,
        FMT_RGB555 = 2'd2,
        FMT_RGB444 = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic uv_swap;
        logic yc_swap;
        logic pclk_neg;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{fmt: FMT_YUV422, uv_swap: 1'b0,
                                   yc_swap: 1'b1, pclk_neg: 1'b0};

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] cr;
        logic             odd;
    } pix_t;

    function automatic logic [PIX_W-1:0] sat_pix(input logic signed [31:0] v);
        if (v < 0)
            return '0;
        else if (v > PIX_MAX)
            return '1;
        else
            return v[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/camfmt_cfg_latch.sv
module camfmt_cfg_latch
    import camfmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] fmt_i,
    input  logic       uv_i,
    input  logic       yc_i,
    input  logic       neg_i,
    output cfg_t       cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (frame_start)
            cfg_d = '{fmt: fmt_e'(fmt_i), uv_swap: uv_i, yc_swap: yc_i, pclk_neg: neg_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else
            cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R8: the captured layout never moves except on a frame start
    a_r8_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg_q));

endmodule

// File: rtl/camfmt_pack.sv
module camfmt_pack
    import camfmt_pkg::*;
#(
    parameter int COEF_FRAC = 8,
    parameter int K_RV      = 359,
    parameter int K_GU      = 88,
    parameter int K_GV      = 183,
    parameter int K_BU      = 454
) (
    input  pix_t             pix,
    input  fmt_e             fmt,
    input  logic             uv_swap,
    input  logic             yc_swap,
    output logic [PIX_W-1:0] beat_hi,
    output logic [PIX_W-1:0] beat_lo
);

    localparam int HALF = 1 << (COEF_FRAC - 1);
    localparam int MID  = 1 << (PIX_W - 1);

    logic signed [31:0] yv, du, dv, rs, gs, bs;
    logic [PIX_W-1:0]   r8, g8, b8, chroma;
    logic [WORD_W-1:0]  word;

    always_comb begin
        yv = $signed({{(32-PIX_W){1'b0}}, pix.y});
        du = $signed({{(32-PIX_W){1'b0}}, pix.cb}) - MID;
        dv = $signed({{(32-PIX_W){1'b0}}, pix.cr}) - MID;
        rs = yv + ((K_RV * dv + HALF) >>> COEF_FRAC);
        gs = yv - ((K_GU * du + K_GV * dv + HALF) >>> COEF_FRAC);
        bs = yv + ((K_BU * du + HALF) >>> COEF_FRAC);
        r8 = sat_pix(rs);
        g8 = sat_pix(gs);
        b8 = sat_pix(bs);
        chroma = (pix.odd ^ uv_swap) ? pix.cr : pix.cb;
        unique case (fmt)
            FMT_RGB565: word = {r8[PIX_W-1 -: 5], g8[PIX_W-1 -: 6], b8[PIX_W-1 -: 5]};
            FMT_RGB555: word = {1'b0, r8[PIX_W-1 -: 5], g8[PIX_W-1 -: 5], b8[PIX_W-1 -: 5]};
            FMT_RGB444: word = {4'b0000, r8[PIX_W-1 -: 4], g8[PIX_W-1 -: 4], b8[PIX_W-1 -: 4]};
            default:    word = yc_swap ? {chroma, pix.y} : {pix.y, chroma};
        endcase
        beat_hi = word[WORD_W-1:PIX_W];
        beat_lo = word[PIX_W-1:0];
    end

endmodule

// File: rtl/camfmt_serial.sv
module camfmt_serial
    import camfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_valid,
    input  logic [PIX_W-1:0] pix_y,
    input  logic [PIX_W-1:0] pix_cb,
    input  logic [PIX_W-1:0] pix_cr,
    input  logic [PIX_W-1:0] beat_hi,
    input  logic [PIX_W-1:0] beat_lo,
    output pix_t             pix_o,
    output logic             beat_next,
    output logic [PIX_W-1:0] data_o
);

    typedef struct packed {
        logic             ph;
        logic             p1;
        logic             odd;
        pix_t             pix;
        logic [PIX_W-1:0] data;
        logic             act;
    } ser_t;

    ser_t s_d, s_q;
    logic first_d, second_d, take_d;

    always_comb begin
        s_d      = s_q;
        take_d   = line_valid && !s_q.ph;
        first_d  = line_valid && s_q.ph;
        second_d = s_q.p1;
        s_d.ph   = take_d;
        s_d.p1   = first_d;
        if (take_d) begin
            s_d.pix = '{y: pix_y, cb: pix_cb, cr: pix_cr, odd: s_q.odd};
            s_d.odd = !s_q.odd;
        end
        if (!line_valid)
            s_d.odd = 1'b0;
        s_d.act  = first_d || second_d;
        s_d.data = first_d ? beat_hi : (second_d ? beat_lo : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign pix_o     = s_q.pix;
    assign beat_next = s_d.act;
    assign data_o    = s_q.data;

    // R2: a first byte is always followed by the second byte of the pair
    a_r2_pair_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.act) |=> s_q.act);

endmodule

// File: rtl/camfmt_sync.sv
module camfmt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid,
    input  logic beat_next,
    input  logic vs_inv,
    input  logic hs_inv,
    input  logic hs_in_vs,
    input  logic pclk_gate,
    output logic frame_start,
    output logic vsync_o,
    output logic hsync_o,
    output logic pclk_en_o
);

    typedef struct packed {
        logic fv;
        logic vs;
        logic hs;
        logic pen;
    } sync_t;

    localparam sync_t SYNC_RESET = '{fv: 1'b0, vs: 1'b1, hs: 1'b1, pen: 1'b0};

    sync_t y_d, y_q;
    logic  vs_act_d, hs_act_d;

    always_comb begin
        y_d      = y_q;
        vs_act_d = y_q.fv;
        hs_act_d = beat_next && (hs_in_vs ? vs_act_d : 1'b1);
        y_d.fv   = frame_valid;
        y_d.vs   = vs_act_d ^ vs_inv;
        y_d.hs   = hs_act_d ^ hs_inv;
        y_d.pen  = pclk_gate ? (hs_act_d && vs_act_d) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            y_q <= SYNC_RESET;
        else
            y_q <= y_d;
    end

    assign frame_start = frame_valid && !y_q.fv;
    assign vsync_o     = y_q.vs;
    assign hsync_o     = y_q.hs;
    assign pclk_en_o   = y_q.pen;

    logic [1:0] warm_d, warm_q;
    always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            warm_q <= '0;
        else
            warm_q <= warm_d;
    end

    // R9: vsync is frame-valid one cycle late with the live polarity
    a_r9_vsync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (vsync_o == ($past(frame_valid, 2) ^ $past(vs_inv))));

    // R10: with qualification on, an active hsync only occurs under an active vsync
    a_r10_hs_inside_vs: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q >= 2'd1) && $past(hs_in_vs) && (hsync_o ^ $past(hs_inv)))
        |-> (vsync_o ^ $past(vs_inv)));

    // R11: ungated pixel clock runs continuously
    a_r11_free_running: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q >= 2'd1) && !$past(pclk_gate)) |-> pclk_en_o);

endmodule

// File: rtl/cam_pix_formatter.sv
module cam_pix_formatter
    import camfmt_pkg::*;
#(
    parameter int COEF_FRAC = 8,
    parameter int K_RV      = 359,
    parameter int K_GU      = 88,
    parameter int K_GV      = 183,
    parameter int K_BU      = 454
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_valid,
    input  logic       line_valid,
    input  logic [7:0] pix_y,
    input  logic [7:0] pix_cb,
    input  logic [7:0] pix_cr,
    input  logic [1:0] cfg_format,
    input  logic       cfg_uv_swap,
    input  logic       cfg_yc_swap,
    input  logic       cfg_vsync_inv,
    input  logic       cfg_hsync_inv,
    input  logic       cfg_pclk_inv,
    input  logic       cfg_pclk_gate,
    input  logic       cfg_hsync_in_vsync,
    output logic [7:0] cam_data,
    output logic       cam_pclk_en,
    output logic       cam_pclk_neg,
    output logic       cam_hsync,
    output logic       cam_vsync
);

    cfg_t             cfg_q;
    pix_t             held_pix;
    logic             frame_start, beat_next;
    logic [PIX_W-1:0] beat_hi, beat_lo;

    camfmt_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .fmt_i       (cfg_format),
        .uv_i        (cfg_uv_swap),
        .yc_i        (cfg_yc_swap),
        .neg_i       (cfg_pclk_inv),
        .cfg_o       (cfg_q)
    );

    camfmt_serial u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_valid (line_valid),
        .pix_y      (pix_y),
        .pix_cb     (pix_cb),
        .pix_cr     (pix_cr),
        .beat_hi    (beat_hi),
        .beat_lo    (beat_lo),
        .pix_o      (held_pix),
        .beat_next  (beat_next),
        .data_o     (cam_data)
    );

    camfmt_pack #(
        .COEF_FRAC (COEF_FRAC),
        .K_RV      (K_RV),
        .K_GU      (K_GU),
        .K_GV      (K_GV),
        .K_BU      (K_BU)
    ) u_pack (
        .pix     (held_pix),
        .fmt     (cfg_q.fmt),
        .uv_swap (cfg_q.uv_swap),
        .yc_swap (cfg_q.yc_swap),
        .beat_hi (beat_hi),
        .beat_lo (beat_lo)
    );

    camfmt_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .beat_next   (beat_next),
        .vs_inv      (cfg_vsync_inv),
        .hs_inv      (cfg_hsync_inv),
        .hs_in_vs    (cfg_hsync_in_vsync),
        .pclk_gate   (cfg_pclk_gate),
        .frame_start (frame_start),
        .vsync_o     (cam_vsync),
        .hsync_o     (cam_hsync),
        .pclk_en_o   (cam_pclk_en)
    );

    assign cam_pclk_neg = cfg_q.pclk_neg;

endmodule

// File: tb/cam_pix_formatter_tb.sv
module cam_pix_formatter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0, line_valid = 1'b0;
    logic [7:0] pix_y = '0, pix_cb = '0, pix_cr = '0;
    logic [1:0] cfg_format = 2'd0;
    logic       cfg_uv_swap = 1'b0, cfg_yc_swap = 1'b1;
    logic       cfg_vsync_inv = 1'b1, cfg_hsync_inv = 1'b1;
    logic       cfg_pclk_inv = 1'b0, cfg_pclk_gate = 1'b0, cfg_hsync_in_vsync = 1'b0;
    logic [7:0] cam_data;
    logic       cam_pclk_en, cam_pclk_neg, cam_hsync, cam_vsync;

    cam_pix_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .line_valid(line_valid),
        .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
        .cfg_format(cfg_format), .cfg_uv_swap(cfg_uv_swap), .cfg_yc_swap(cfg_yc_swap),
        .cfg_vsync_inv(cfg_vsync_inv), .cfg_hsync_inv(cfg_hsync_inv),
        .cfg_pclk_inv(cfg_pclk_inv), .cfg_pclk_gate(cfg_pclk_gate),
        .cfg_hsync_in_vsync(cfg_hsync_in_vsync),
        .cam_data(cam_data), .cam_pclk_en(cam_pclk_en), .cam_pclk_neg(cam_pclk_neg),
        .cam_hsync(cam_hsync), .cam_vsync(cam_vsync)
    );

    always #4 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit chk_en = 0, done = 0, mid_chg = 0;

    // reference model state
    logic [7:0] bq[$];
    int    m_fmt = 0, m_uv = 0, m_yc = 1, m_neg = 0, m_fvp = 0, m_cnt = 0;
    int    e_data = 0, e_pen = 0, e_neg = 0, e_hs = 1, e_vs = 1;
    string t_data = "R1", t_hs = "R1", t_vs = "R1", t_pen = "R1", t_neg = "R1";

    function automatic int clip(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic void push_pixel(input int y, input int cb, input int cr, input int idx);
        int u, v, r, g, b, w, ch;
        u = cb - 128;
        v = cr - 128;
        r = clip(y + ((359 * v + 128) >>> 8));
        g = clip(y - ((88 * u + 183 * v + 128) >>> 8));
        b = clip(y + ((454 * u + 128) >>> 8));
        case (m_fmt)
            1: w = ((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3);
            2: w = ((r >> 3) << 10) | ((g >> 3) << 5) | (b >> 3);
            3: w = ((r >> 4) << 8) | ((g >> 4) << 4) | (b >> 4);
            default: begin
                ch = (((idx % 2) == 1) != (m_uv == 1)) ? cr : cb;
                w  = (m_yc == 1) ? ((ch << 8) | y) : ((y << 8) | ch);
            end
        endcase
        bq.push_back(8'((w >> 8) & 255));
        bq.push_back(8'(w & 255));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bq.delete();
            m_fmt = 0; m_uv = 0; m_yc = 1; m_neg = 0; m_fvp = 0; m_cnt = 0;
            e_data = 0; e_pen = 0; e_neg = 0; e_hs = 1; e_vs = 1;
            t_data = "R1"; t_hs = "R1"; t_vs = "R1"; t_pen = "R1"; t_neg = "R1";
        end else begin
            int  d, hs_act;
            bit  vld;
            if (frame_valid && m_fvp == 0) begin
                m_fmt = int'(cfg_format); m_uv = int'(cfg_uv_swap);
                m_yc = int'(cfg_yc_swap); m_neg = int'(cfg_pclk_inv);
            end
            vld = (bq.size() > 0);
            d = vld ? int'(bq.pop_front()) : 0;
            if (line_valid) begin
                if (m_cnt % 2 == 0) push_pixel(int'(pix_y), int'(pix_cb), int'(pix_cr), m_cnt / 2);
                m_cnt++;
            end else begin
                m_cnt = 0;
            end
            hs_act = (vld && (cfg_hsync_in_vsync ? m_fvp == 1 : 1'b1)) ? 1 : 0;
            e_data = d;
            e_vs   = m_fvp ^ int'(cfg_vsync_inv);
            e_hs   = hs_act ^ int'(cfg_hsync_inv);
            e_pen  = cfg_pclk_gate ? ((hs_act == 1 && m_fvp == 1) ? 1 : 0) : 1;
            e_neg  = m_neg;
            if (!vld)            t_data = "R2";
            else if (m_fmt == 0) t_data = "R2 R3";
            else if (m_fmt == 1) t_data = "R4 R5";
            else if (m_fmt == 2) t_data = "R4 R6";
            else                 t_data = "R4 R7";
            if (mid_chg) t_data = {t_data, " R8"};
            t_vs  = "R9";
            t_hs  = "R10";
            t_pen = "R11";
            t_neg = mid_chg ? "R12 R8" : "R12";
            m_fvp = int'(frame_valid);
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual 0x%0h expected 0x%0h", tag, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(t_data, "cam_data", int'(cam_data), e_data);
            check(t_vs, "cam_vsync", int'(cam_vsync), e_vs);
            check(t_hs, "cam_hsync", int'(cam_hsync), e_hs);
            check(t_pen, "cam_pclk_en", int'(cam_pclk_en), e_pen);
            check(t_neg, "cam_pclk_neg", int'(cam_pclk_neg), e_neg);
        end
    end

    task automatic set_pixel(input int l, input int p, input int seed);
        if (p == 0)      begin pix_y = 8'd255; pix_cb = 8'd0;   pix_cr = 8'd255; end
        else if (p == 1) begin pix_y = 8'd0;   pix_cb = 8'd255; pix_cr = 8'd0;   end
        else if (p == 2) begin pix_y = 8'd128; pix_cb = 8'd128; pix_cr = 8'd128; end
        else begin
            pix_y  = 8'((seed * 37 + p * 53 + l * 11) & 255);
            pix_cb = 8'((seed * 91 + p * 29 + l * 7) & 255);
            pix_cr = 8'((seed * 13 + p * 71 + l * 5) & 255);
        end
    endtask

    task automatic run_line(input int l, input int ppl, input int seed);
        line_valid = 1'b1;
        for (int p = 0; p < ppl; p++) begin
            set_pixel(l, p, seed);
            @(negedge clk);
            @(negedge clk);
        end
        line_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(input int lines, input int ppl, input int seed, input int chg_line);
        frame_valid = 1'b1;
        repeat (2) @(negedge clk);
        for (int l = 0; l < lines; l++) begin
            if (l == chg_line) begin
                mid_chg      = 1;
                cfg_format   = 2'd3;
                cfg_uv_swap  = ~cfg_uv_swap;
                cfg_yc_swap  = ~cfg_yc_swap;
                cfg_pclk_inv = ~cfg_pclk_inv;
            end
            run_line(l, ppl, seed);
        end
        frame_valid = 1'b0;
        repeat (6) @(negedge clk);
        mid_chg = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) chk_en = 1;              // R1 reset values checked here
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R3 default: chroma first
        run_frame(2, 6, 1, -1);
        // R3 luma first, chroma swapped
        cfg_yc_swap = 1'b0; cfg_uv_swap = 1'b1;
        run_frame(2, 6, 2, -1);
        // R5 with non-inverted vsync
        cfg_format = 2'd1; cfg_uv_swap = 1'b0; cfg_yc_swap = 1'b1; cfg_vsync_inv = 1'b0;
        run_frame(2, 8, 3, -1);
        // R6 with falling-edge select and non-inverted hsync (R12)
        cfg_format = 2'd2; cfg_pclk_inv = 1'b1; cfg_hsync_inv = 1'b0; cfg_vsync_inv = 1'b1;
        run_frame(2, 8, 4, -1);
        // R7 with gating and hsync qualification, then blanking lines (R10, R11)
        cfg_format = 2'd3; cfg_pclk_gate = 1'b1; cfg_hsync_in_vsync = 1'b1; cfg_pclk_inv = 1'b0;
        run_frame(2, 8, 5, -1);
        run_line(0, 5, 6);
        cfg_hsync_in_vsync = 1'b0;
        run_line(1, 5, 7);
        cfg_pclk_gate = 1'b0;
        run_line(2, 4, 8);
        repeat (4) @(negedge clk);
        // R8: layout controls flipped after the first line must not apply
        cfg_format = 2'd1; cfg_uv_swap = 1'b0; cfg_yc_swap = 1'b1; cfg_pclk_inv = 1'b0;
        run_frame(3, 6, 9, 1);
        // next frame picks up the flipped controls; then a full nominal-width line
        run_frame(1, 6, 10, -1);
        cfg_format = 2'd0; cfg_yc_swap = 1'b1; cfg_uv_swap = 1'b0;
        run_frame(1, 640, 11, -1);
        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule